// File: doc/BRIEF.md
# Configurable PLD Macrocell

This block models one programmable cell of an erasable programmable logic device. A shared input vector feeds a set of product terms. Each term is an AND of chosen true and chosen complemented inputs. The enabled terms are ORed into one sum, and a polarity bit can complement that sum. The cell then either drives the result straight to the pin path or stores it in a flip-flop. The flip-flop can act as a D or a T element and can trigger on either clock edge.

Two extra product terms carry control. The control term has a different job in each mode. In synchronous mode it drives the output enable and the flip-flop runs from the global clock. In asynchronous mode the same term becomes the flip-flop's clock and the output enable is held high. The clear term resets the flip-flop asynchronously. A feedback output returns either the stored bit or the pin value to the array. All programming is given as static configuration inputs that stand in for the device's storage cells.

Top module: `mc_macrocell`

## Requirements
- R1: A product term is 1 when every input selected in its true mask is 1 and every input selected in its complement mask is 0. A term with no mask bits set is 1. A term that selects the same input in both masks is always 0.
- R2: The sum is the OR of the product terms whose enable bit is set. With no term enabled the sum is 0.
- R3: When `cfg_invert` is 1, the logic value is the complement of the sum. When it is 0, the logic value equals the sum.
- R4: When `cfg_out_reg` is 0, `pin_out` follows the logic value with no clock. When it is 1, `pin_out` is the flip-flop output and changes only on a clock edge or a clear.
- R5: When `cfg_async` is 0, the flip-flop is clocked by `clk_glb` and `pin_oe` equals the control product term.
- R6: When `cfg_async` is 1, `pin_oe` is 1 whatever the control term is, the flip-flop is clocked by the control product term, and `clk_glb` edges have no effect on it.
- R7: When `cfg_toggle` is 0, the flip-flop loads the logic value on its active edge. When it is 1, the flip-flop inverts its state on an active edge where the logic value is 1 and keeps its state where it is 0.
- R8: When `cfg_negedge` is 0, the active edge is the rising edge of the selected clock. When it is 1, the active edge is the falling edge.
- R9: When `cfg_clr_en` is 1 and the clear product term is 1, the flip-flop goes to 0 at once and stays 0 through any clock edge while the clear lasts. When `cfg_clr_en` is 0, the clear term has no effect.
- R10: When `cfg_fb_reg` is 1, `fb_out` is the flip-flop output. When it is 0, `fb_out` equals `pin_out`.
- R11: While `rst_n` is 0, the flip-flop output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_glb | input | 1 | Global clock |
| rst_n | input | 1 | Asynchronous active-low device reset of the flip-flop |
| arr_in | input | N_IN | Shared array inputs |
| cfg_pt_true | input | N_PT*N_IN | True-input masks; term t uses bits [t*N_IN +: N_IN] |
| cfg_pt_comp | input | N_PT*N_IN | Complement-input masks, laid out the same way |
| cfg_pt_en | input | N_PT | Per-term enable for the sum |
| cfg_ctl_true | input | N_IN | True mask of the control term |
| cfg_ctl_comp | input | N_IN | Complement mask of the control term |
| cfg_clr_true | input | N_IN | True mask of the clear term |
| cfg_clr_comp | input | N_IN | Complement mask of the clear term |
| cfg_clr_en | input | 1 | Clear term enable |
| cfg_invert | input | 1 | Complement the sum |
| cfg_async | input | 1 | 1: local clock from the control term, output always enabled |
| cfg_toggle | input | 1 | 1: T flip-flop, 0: D flip-flop |
| cfg_negedge | input | 1 | 1: falling-edge triggered |
| cfg_out_reg | input | 1 | 1: pin driven from the flip-flop |
| cfg_fb_reg | input | 1 | 1: feedback from the flip-flop, 0: from the pin |
| pin_out | output | 1 | Pin data value |
| pin_oe | output | 1 | Pin output enable |
| fb_out | output | 1 | Feedback to the array |

## Verification
The bench checks terms with empty masks and with contradictory masks, and it checks the sum with every term disabled. A design that treated an empty mask as 0, or ORed in disabled terms, would give the wrong combinational pin value. In asynchronous mode it runs global clock edges with new data held and expects the register not to move. It also expects only the chosen edge of the control term to load the register and the enable to stay high. A design that left the global clock in the path or gated the enable would fail there. Falling-edge capture is checked in the half cycle between edges. The clear is held across several clock edges to show that it takes priority, and it is checked again with its enable removed to show that it then has no effect.

// File: rtl/mc_pkg.sv
package mc_pkg;

    typedef enum logic {
        CLK_SRC_GLOBAL = 1'b0,
        CLK_SRC_LOCAL  = 1'b1
    } mc_clk_src_e;

    typedef struct packed {
        logic q;
    } mc_reg_t;

endpackage

// File: rtl/mc_pterm.sv
module mc_pterm #(
    parameter int N_IN = 8
) (
    input  logic [N_IN-1:0] in_vec,
    input  logic [N_IN-1:0] true_mask,
    input  logic [N_IN-1:0] comp_mask,
    output logic            term
);
    logic [N_IN-1:0] lit_ok;

    // each input position passes unless a selected literal is false there
    always_comb begin
        for (int i = 0; i < N_IN; i++) begin
            lit_ok[i] = (~true_mask[i] | in_vec[i]) & (~comp_mask[i] | ~in_vec[i]);
        end
        term = &lit_ok;
    end
endmodule

// File: rtl/mc_sum_array.sv
module mc_sum_array #(
    parameter int N_IN = 8,
    parameter int N_PT = 8
) (
    input  logic [N_IN-1:0]      in_vec,
    input  logic [N_PT*N_IN-1:0] true_masks,
    input  logic [N_PT*N_IN-1:0] comp_masks,
    input  logic [N_PT-1:0]      term_en,
    input  logic                 invert,
    output logic                 logic_val
);
    logic [N_PT-1:0] terms;
    logic            sum;

    for (genvar t = 0; t < N_PT; t++) begin : g_term
        mc_pterm #(.N_IN(N_IN)) u_pt (
            .in_vec    (in_vec),
            .true_mask (true_masks[t*N_IN +: N_IN]),
            .comp_mask (comp_masks[t*N_IN +: N_IN]),
            .term      (terms[t])
        );
    end

    always_comb begin
        sum       = |(terms & term_en);
        logic_val = sum ^ invert;
    end
endmodule

// File: rtl/mc_flop.sv
module mc_flop
    import mc_pkg::*;
(
    input  logic ff_clk,
    input  logic ff_clr,
    input  logic toggle,
    input  logic data,
    output logic q
);
    mc_reg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (toggle) begin
            st_d.q = st_q.q ^ data;
        end else begin
            st_d.q = data;
        end
    end

    always_ff @(posedge ff_clk or posedge ff_clr) begin
        if (ff_clr) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.q;
endmodule

// File: rtl/mc_macrocell.sv
module mc_macrocell
    import mc_pkg::*;
#(
    parameter int N_IN = 8,
    parameter int N_PT = 8
) (
    input  logic                 clk_glb,
    input  logic                 rst_n,
    input  logic [N_IN-1:0]      arr_in,
    input  logic [N_PT*N_IN-1:0] cfg_pt_true,
    input  logic [N_PT*N_IN-1:0] cfg_pt_comp,
    input  logic [N_PT-1:0]      cfg_pt_en,
    input  logic [N_IN-1:0]      cfg_ctl_true,
    input  logic [N_IN-1:0]      cfg_ctl_comp,
    input  logic [N_IN-1:0]      cfg_clr_true,
    input  logic [N_IN-1:0]      cfg_clr_comp,
    input  logic                 cfg_clr_en,
    input  logic                 cfg_invert,
    input  logic                 cfg_async,
    input  logic                 cfg_toggle,
    input  logic                 cfg_negedge,
    input  logic                 cfg_out_reg,
    input  logic                 cfg_fb_reg,
    output logic                 pin_out,
    output logic                 pin_oe,
    output logic                 fb_out
);
    logic        sum_f;
    logic        ctl_pt;
    logic        clr_pt;
    logic        clr_act;
    logic        ff_clr;
    logic        src_clk;
    logic        ff_clk;
    logic        q;
    mc_clk_src_e clk_src;

    mc_sum_array #(.N_IN(N_IN), .N_PT(N_PT)) u_sum (
        .in_vec     (arr_in),
        .true_masks (cfg_pt_true),
        .comp_masks (cfg_pt_comp),
        .term_en    (cfg_pt_en),
        .invert     (cfg_invert),
        .logic_val  (sum_f)
    );

    mc_pterm #(.N_IN(N_IN)) u_ctl_pt (
        .in_vec    (arr_in),
        .true_mask (cfg_ctl_true),
        .comp_mask (cfg_ctl_comp),
        .term      (ctl_pt)
    );

    mc_pterm #(.N_IN(N_IN)) u_clr_pt (
        .in_vec    (arr_in),
        .true_mask (cfg_clr_true),
        .comp_mask (cfg_clr_comp),
        .term      (clr_pt)
    );

    // clock source and edge selection, clear and enable routing
    always_comb begin
        clk_src = cfg_async ? CLK_SRC_LOCAL : CLK_SRC_GLOBAL;
        src_clk = (clk_src == CLK_SRC_LOCAL) ? ctl_pt : clk_glb;
        ff_clk  = src_clk ^ cfg_negedge;
        clr_act = clr_pt & cfg_clr_en;
        ff_clr  = clr_act | ~rst_n;
        pin_oe  = (clk_src == CLK_SRC_LOCAL) ? 1'b1 : ctl_pt;
    end

    mc_flop u_ff (
        .ff_clk (ff_clk),
        .ff_clr (ff_clr),
        .toggle (cfg_toggle),
        .data   (sum_f),
        .q      (q)
    );

    // output and feedback multiplexers
    always_comb begin
        pin_out = cfg_out_reg ? q : sum_f;
        fb_out  = cfg_fb_reg ? q : pin_out;
    end
endmodule

// File: rtl/mc_macrocell_chk.sv
module mc_macrocell_chk (
    input logic clk_glb,
    input logic rst_n,
    input logic cfg_async,
    input logic cfg_out_reg,
    input logic cfg_fb_reg,
    input logic sum_f,
    input logic ctl_pt,
    input logic clr_act,
    input logic q,
    input logic pin_out,
    input logic pin_oe,
    input logic fb_out
);
    AST_ASYNC_OE_HIGH: assert property (@(posedge clk_glb) disable iff (!rst_n)
        cfg_async |-> pin_oe);                                   // R6
    AST_SYNC_OE_FROM_TERM: assert property (@(posedge clk_glb) disable iff (!rst_n)
        !cfg_async |-> (pin_oe == ctl_pt));                      // R5
    AST_CLEAR_HOLDS_ZERO: assert property (@(posedge clk_glb) disable iff (!rst_n)
        clr_act |-> (q == 1'b0));                                // R9
    AST_COMB_PIN: assert property (@(posedge clk_glb) disable iff (!rst_n)
        !cfg_out_reg |-> (pin_out == sum_f));                    // R4
    AST_REG_PIN: assert property (@(posedge clk_glb) disable iff (!rst_n)
        cfg_out_reg |-> (pin_out == q));                         // R4
    AST_FB_FROM_REG: assert property (@(posedge clk_glb) disable iff (!rst_n)
        cfg_fb_reg |-> (fb_out == q));                           // R10
    AST_FB_FROM_PIN: assert property (@(posedge clk_glb) disable iff (!rst_n)
        !cfg_fb_reg |-> (fb_out == pin_out));                    // R10
endmodule

bind mc_macrocell mc_macrocell_chk u_chk (
    .clk_glb     (clk_glb),
    .rst_n       (rst_n),
    .cfg_async   (cfg_async),
    .cfg_out_reg (cfg_out_reg),
    .cfg_fb_reg  (cfg_fb_reg),
    .sum_f       (sum_f),
    .ctl_pt      (ctl_pt),
    .clr_act     (clr_act),
    .q           (q),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe),
    .fb_out      (fb_out)
);

// File: tb/mc_macrocell_tb_top.sv
module mc_macrocell_tb_top;
    localparam int N_IN = 8;
    localparam int N_PT = 8;

    logic                 clk_glb = 1'b0;
    logic                 rst_n;
    logic [N_IN-1:0]      arr_in;
    logic [N_PT*N_IN-1:0] pt_true, pt_comp;
    logic [N_PT-1:0]      pt_en;
    logic [N_IN-1:0]      ctl_true, ctl_comp, clr_true, clr_comp;
    logic clr_en, invert, async_m, toggle, negedge_m, out_reg, fb_reg;
    logic pin_out, pin_oe, fb_out;

    int  n_checks = 0;
    int  n_errors = 0;
    logic q_m;

    always #5 clk_glb = ~clk_glb;

    mc_macrocell #(.N_IN(N_IN), .N_PT(N_PT)) dut_i (
        .clk_glb(clk_glb), .rst_n(rst_n), .arr_in(arr_in),
        .cfg_pt_true(pt_true), .cfg_pt_comp(pt_comp), .cfg_pt_en(pt_en),
        .cfg_ctl_true(ctl_true), .cfg_ctl_comp(ctl_comp),
        .cfg_clr_true(clr_true), .cfg_clr_comp(clr_comp), .cfg_clr_en(clr_en),
        .cfg_invert(invert), .cfg_async(async_m), .cfg_toggle(toggle),
        .cfg_negedge(negedge_m), .cfg_out_reg(out_reg), .cfg_fb_reg(fb_reg),
        .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
    );

    // behavioral reference of the programmed logic value
    function automatic logic ref_f(input logic [N_IN-1:0] v);
        logic acc, hit;
        acc = 1'b0;
        for (int t = 0; t < N_PT; t++) begin
            if (pt_en[t]) begin
                hit = 1'b1;
                for (int i = 0; i < N_IN; i++) begin
                    if (pt_true[t*N_IN+i] && !v[i]) hit = 1'b0;
                    if (pt_comp[t*N_IN+i] && v[i])  hit = 1'b0;
                end
                if (hit) acc = 1'b1;
            end
        end
        return invert ? !acc : acc;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk_glb);
        #2;
    endtask

    // pulse the clear term (bit 6) so the register state is known after a mode change
    task automatic resync();
        logic keep;
        keep = clr_en;
        clr_en = 1'b1;
        arr_in[6] = 1'b1;
        #1;
        arr_in[6] = 1'b0;
        #1;
        clr_en = keep;
        q_m = 1'b0;
        step();
    endtask

    task automatic test_reset();
        out_reg = 1'b1;
        arr_in = 8'h03;
        step();
        step();
        check("R11 reset pin", pin_out, 1'b0);
        check("R11 reset fb", fb_out, 1'b0);
        rst_n = 1'b1;
        arr_in = 8'h00;
        step();
        q_m = 1'b0;
    endtask

    task automatic test_comb();
        logic [N_IN-1:0] pats [7] = '{8'h00, 8'h03, 8'h08, 8'h0C, 8'h04, 8'h0F, 8'h01};
        out_reg = 1'b0;
        foreach (pats[k]) begin
            arr_in = pats[k];
            #1;
            check("R2 sum vs reference", pin_out, ref_f(pats[k]));
        end
        arr_in = 8'h03; #1; check("R1 true literals", pin_out, 1'b1);
        arr_in = 8'h0C; #1; check("R1 complement literal blocks", pin_out, 1'b0);
        pt_en[2] = 1'b1;
        arr_in = 8'h00; #1; check("R1 empty term is 1", pin_out, 1'b1);
        pt_en[2] = 1'b0;
        pt_true[3*N_IN+4] = 1'b1;
        pt_comp[3*N_IN+4] = 1'b1;
        pt_en[3] = 1'b1;
        arr_in = 8'h10; #1; check("R1 contradictory term high in", pin_out, 1'b0);
        arr_in = 8'h00; #1; check("R1 contradictory term low in", pin_out, 1'b0);
        pt_en[3] = 1'b0;
        pt_en = '0;
        arr_in = 8'h03; #1; check("R2 no terms enabled", pin_out, 1'b0);
        pt_en = 8'b0000_0011;
        invert = 1'b1;
        arr_in = 8'h03; #1; check("R3 inverted true", pin_out, 1'b0);
        arr_in = 8'h00; #1; check("R3 inverted false", pin_out, 1'b1);
        invert = 1'b0;
        #1;
    endtask

    task automatic test_sync_d();
        logic [N_IN-1:0] seq [5] = '{8'h03, 8'h00, 8'h08, 8'h0F, 8'h04};
        out_reg = 1'b1; async_m = 1'b0; negedge_m = 1'b0; toggle = 1'b0;
        resync();
        foreach (seq[k]) begin
            arr_in = seq[k];
            #2;
            check("R4 registered pin waits for edge", pin_out, q_m);
            step();
            q_m = ref_f(seq[k]);
            check("R5 D capture on global edge", pin_out, q_m);
        end
        arr_in = 8'h80; #1; check("R5 oe follows control term high", pin_oe, 1'b1);
        arr_in = 8'h00; #1; check("R5 oe follows control term low", pin_oe, 1'b0);
        step();
    endtask

    task automatic test_toggle();
        toggle = 1'b1;
        resync();
        arr_in = 8'h03;
        for (int k = 0; k < 3; k++) begin
            step();
            q_m = !q_m;
            check("R7 toggle on logic 1", pin_out, q_m);
        end
        arr_in = 8'h00;
        for (int k = 0; k < 2; k++) begin
            step();
            check("R7 hold on logic 0", pin_out, q_m);
        end
        toggle = 1'b0;
    endtask

    task automatic test_negedge();
        negedge_m = 1'b0;
        resync();
        arr_in = 8'h03;
        #5;
        check("R8 rising mode ignores falling edge", pin_out, 1'b0);
        step();
        negedge_m = 1'b1;
        resync();
        arr_in = 8'h03;
        #5;
        check("R8 falling edge captures", pin_out, 1'b1);
        step();
        arr_in = 8'h00;
        #5;
        check("R8 falling edge captures zero", pin_out, 1'b0);
        step();
        negedge_m = 1'b0;
    endtask

    task automatic test_async();
        async_m = 1'b1; negedge_m = 1'b0; toggle = 1'b0; out_reg = 1'b1;
        arr_in = 8'h00;
        resync();
        check("R6 oe high with control term low", pin_oe, 1'b1);
        arr_in = 8'h03;
        step(); step(); step();
        check("R6 global clock ignored", pin_out, 1'b0);
        arr_in[7] = 1'b1; #1;
        check("R6 local rising edge captures", pin_out, 1'b1);
        arr_in[1:0] = 2'b00; #1;
        arr_in[7] = 1'b0; #1;
        check("R6 local falling edge ignored", pin_out, 1'b1);
        arr_in[7] = 1'b1; #1;
        check("R6 local rising edge captures zero", pin_out, 1'b0);
        check("R6 oe high with control term high", pin_oe, 1'b1);
        negedge_m = 1'b1;
        arr_in = 8'h83;
        resync();
        arr_in[7] = 1'b0; #1;
        check("R8 local falling edge captures", pin_out, 1'b1);
        async_m = 1'b0; negedge_m = 1'b0;
        arr_in = 8'h00;
        resync();
    endtask

    task automatic test_clear();
        arr_in = 8'h03;
        step();
        check("R9 setup value", pin_out, 1'b1);
        arr_in = 8'h43; #1;
        check("R9 clear immediate", pin_out, 1'b0);
        step(); step();
        check("R9 clear beats clock", pin_out, 1'b0);
        arr_in = 8'h03;
        step();
        check("R9 release then capture", pin_out, 1'b1);
        clr_en = 1'b0;
        arr_in = 8'h43; #1;
        check("R9 disabled clear no effect", pin_out, 1'b1);
        step();
        check("R9 disabled clear through edge", pin_out, 1'b1);
        arr_in = 8'h03;
        clr_en = 1'b1;
        #1;
    endtask

    task automatic test_fb();
        // register holds 1 from the clear test
        fb_reg = 1'b1; out_reg = 1'b0;
        arr_in = 8'h00; #1;
        check("R10 comb pin with reg feedback", pin_out, 1'b0);
        check("R10 feedback from register", fb_out, 1'b1);
        fb_reg = 1'b0; #1;
        check("R10 feedback from pin", fb_out, 1'b0);
        arr_in = 8'h08; #1;
        check("R10 feedback tracks pin", fb_out, 1'b1);
    endtask

    initial begin
        #(200000 * 10);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        arr_in = '0;
        pt_true = '0; pt_comp = '0; pt_en = '0;
        ctl_true = '0; ctl_comp = '0; clr_true = '0; clr_comp = '0;
        clr_en = 1'b0; invert = 1'b0; async_m = 1'b0; toggle = 1'b0;
        negedge_m = 1'b0; out_reg = 1'b0; fb_reg = 1'b0;
        q_m = 1'b0;
        // term0: in0 & in1; term1: in3 & ~in2; control: in7; clear: in6
        pt_true[0*N_IN +: N_IN] = 8'h03;
        pt_true[1*N_IN +: N_IN] = 8'h08;
        pt_comp[1*N_IN +: N_IN] = 8'h04;
        pt_en = 8'b0000_0011;
        ctl_true = 8'h80;
        clr_true = 8'h40;
        clr_en = 1'b1;
        test_reset();
        test_comb();
        test_sync_d();
        test_toggle();
        test_negedge();
        test_async();
        test_clear();
        test_fb();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule